// File: doc/BRIEF.md
# Oscilloscope Sweep Gate Controller

This block decides, one clock at a time, when the horizontal ramp of a sampled-display timebase may start. A sweep ends when the ramp reports that it has reached its end. The block then opens a programmable holdoff interval, emits a one-cycle alternate-sync pulse and drops the sweep gate, so the ramp is held in reset. Once the holdoff count has run out and the ramp reports that its reset has finished, trigger arming resumes. A two-stage arming chain then opens the gate on the first rising trigger transition that follows. The first stage follows the low level of the trigger, and the second stage captures on a rising transition.

Three modes are selected. Normal mode sweeps only on a valid trigger. Auto mode adds a free-run path: once no rising trigger edge has been seen for a set number of cycles, the gate is forced open at the end of every holdoff. X-Y mode locks out arming and holdoff entirely. An optional delay enable holds the ramp in reset after the gate opens, until an external delay-done flag arrives. All inputs are synchronous to one clock.

Top module: `sweep_gate_ctrl`

## Requirements
- R1: After a synchronous reset, sweep_gate_o is 0, sweep_rst_o is 1 and alt_sync_o is 0.
- R2: When sweep_gate_o is 1, sweep_rst_o is 0 and ramp_done_i is 1 at a clock edge, then after that edge sweep_gate_o is 0, sweep_rst_o is 1 and alt_sync_o is 1 for exactly one cycle.
- R3: The holdoff loads the value hold_len_i had one edge before it starts (N). It releases at the edge N+1 edges after the start edge, provided ramp_done_i is 1 there; otherwise it waits for ramp_done_i. While holdoff lasts, trigger edges do not open the gate.
- R4: Once holdoff has released, the gate opens at the first edge where trig_i is 1 and trig_i was 0 at the previous edge. A low sample taken inside holdoff counts, so a trigger that is low at release opens the gate on the first free edge it rises.
- R5: A trigger that is already high when holdoff releases does not open the gate until it has gone low and risen again.
- R6: sweep_rst_o is 1 whenever sweep_gate_o is 0.
- R7: With dly_en_i at 1, sweep_rst_o stays 1 after the gate opens. It falls at the edge after dly_done_i is sampled 1 with the gate open, and it then stays 0 while the gate is open.
- R8: In auto mode (mode_i = 2'b01), after AUTO_CYC edges without a rising trigger edge, the gate is forced open at the first edge at which holdoff is not active. It therefore free-runs: it opens one edge after each holdoff release.
- R9: In normal mode (mode_i = 2'b00, and also 2'b11), the gate never opens without a rising trigger edge, however long the trigger stays still.
- R10: In X-Y mode (mode_i = 2'b10), the gate is 0 after the next edge, no holdoff starts, no alt_sync_o pulse occurs and trigger edges are ignored.
- R11: A rising trigger edge restarts the auto timeout, so no forced gate follows until AUTO_CYC further edges pass without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Trigger level from the trigger comparator |
| ramp_done_i | input | 1 | Ramp flag: end reached while sweeping, reset finished during holdoff |
| mode_i | input | 2 | 00 normal, 01 auto, 10 X-Y, 11 normal |
| dly_en_i | input | 1 | Hold the ramp after gate until delay done |
| dly_done_i | input | 1 | Delay timebase has expired |
| hold_len_i | input | HOLD_W | Holdoff length in cycles (N gives N+1 cycles) |
| sweep_gate_o | output | 1 | Sweep gate |
| sweep_rst_o | output | 1 | Hold the ramp in reset |
| alt_sync_o | output | 1 | One-cycle pulse at the start of holdoff |

## Verification
The in-line properties check on every cycle that an active holdoff or X-Y mode blocks the gate, and that each gate opening follows a sampled rising trigger or a forced auto opening. They also check that the sync pulse lasts one cycle inside holdoff, that release waits for the ramp flag, and that a rising edge clears the timeout. The exact holdoff length for every count value, the two-edge rule for a trigger that is high at release, and the delay hold-off of the ramp reset can only be shown by the bench's scenarios. So can the timeout instant and free-running period in auto mode, and the absence of free-running in normal mode.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'b00,
        MODE_AUTO = 2'b01,
        MODE_XY   = 2'b10,
        MODE_RSVD = 2'b11
    } sgc_mode_e;

    typedef struct packed {
        logic xy;
        logic auto_en;
    } sgc_mode_ctl_t;

    function automatic sgc_mode_ctl_t decode_mode(input logic [1:0] m);
        sgc_mode_ctl_t c;
        c.xy      = (m == MODE_XY);
        c.auto_en = (m == MODE_AUTO);
        return c;
    endfunction

endpackage

// File: rtl/sgc_holdoff.sv
module sgc_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ramp_done_i,
    input  logic [HOLD_W-1:0] len_i,
    output logic              active_o,
    output logic              alt_sync_o
);
    logic [HOLD_W-1:0] len_q;
    logic [HOLD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            cnt_q      <= '0;
            active_o   <= 1'b0;
            alt_sync_o <= 1'b0;
        end else begin
            len_q      <= len_i;
            alt_sync_o <= start_i;
            if (start_i) begin
                active_o <= 1'b1;
                cnt_q    <= len_q;
            end else if (active_o) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (ramp_done_i) begin
                    active_o <= 1'b0;
                end
            end
        end
    end

    p_alt_single_r2: assert property (@(posedge clk) disable iff (rst)
        alt_sync_o |=> !alt_sync_o);
    p_alt_in_hold_r2: assert property (@(posedge clk) disable iff (rst)
        alt_sync_o |-> active_o);
    p_release_ramp_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> $past(ramp_done_i));
endmodule

// File: rtl/sgc_auto.sv
module sgc_auto #(
    parameter int AUTO_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    output logic timed_out_o
);
    localparam int TW = $clog2(AUTO_CYC + 1);
    localparam logic [TW-1:0] LIMIT = TW'(AUTO_CYC);

    logic [TW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst || rise_i) begin
            idle_q <= '0;
        end else if (idle_q != LIMIT) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign timed_out_o = (idle_q == LIMIT);

    p_rise_clears_r11: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> !timed_out_o);
endmodule

// File: rtl/sgc_arm.sv
module sgc_arm (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic hold_i,
    input  logic xy_i,
    input  logic force_i,
    input  logic start_i,
    input  logic dly_en_i,
    input  logic dly_done_i,
    output logic rise_o,
    output logic gate_o,
    output logic sweep_rst_o
);
    logic trig_q;
    logic stage1_q;
    logic dly_seen_q;
    logic lock;

    assign lock   = hold_i | xy_i;
    assign rise_o = trig_i & ~trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q     <= 1'b1;
            stage1_q   <= 1'b0;
            gate_o     <= 1'b0;
            dly_seen_q <= 1'b0;
        end else begin
            trig_q <= trig_i;
            if (xy_i) begin
                stage1_q <= 1'b0;
            end else begin
                stage1_q <= (stage1_q & ~hold_i) | ~trig_i;
            end
            if (start_i || lock) begin
                gate_o <= 1'b0;
            end else if ((rise_o && stage1_q) || force_i) begin
                gate_o <= 1'b1;
            end
            if (!gate_o) begin
                dly_seen_q <= 1'b0;
            end else if (dly_done_i) begin
                dly_seen_q <= 1'b1;
            end
        end
    end

    assign sweep_rst_o = ~gate_o | (dly_en_i & ~dly_seen_q);

    p_lock_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        lock |=> !gate_o);
    p_xy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        xy_i |=> !gate_o);
    p_gate_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_o) |-> ($past(force_i) || ($past(trig_i) && !$past(trig_i, 2))));
endmodule

// File: rtl/sweep_gate_ctrl.sv
module sweep_gate_ctrl #(
    parameter int HOLD_W   = 8,
    parameter int AUTO_CYC = 20_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              ramp_done_i,
    input  logic [1:0]        mode_i,
    input  logic              dly_en_i,
    input  logic              dly_done_i,
    input  logic [HOLD_W-1:0] hold_len_i,
    output logic              sweep_gate_o,
    output logic              sweep_rst_o,
    output logic              alt_sync_o
);
    import sgc_pkg::*;

    sgc_mode_ctl_t mctl;
    logic hold_act;
    logic start_ho;
    logic rise;
    logic timed_out;
    logic force_gate;

    assign mctl       = decode_mode(mode_i);
    assign start_ho   = sweep_gate_o & ~sweep_rst_o & ramp_done_i & ~mctl.xy;
    assign force_gate = mctl.auto_en & timed_out;

    sgc_holdoff #(.HOLD_W(HOLD_W)) hold_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_ho),
        .ramp_done_i(ramp_done_i),
        .len_i      (hold_len_i),
        .active_o   (hold_act),
        .alt_sync_o (alt_sync_o)
    );

    sgc_auto #(.AUTO_CYC(AUTO_CYC)) auto_i (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .timed_out_o(timed_out)
    );

    sgc_arm arm_i (
        .clk        (clk),
        .rst        (rst),
        .trig_i     (trig_i),
        .hold_i     (hold_act),
        .xy_i       (mctl.xy),
        .force_i    (force_gate),
        .start_i    (start_ho),
        .dly_en_i   (dly_en_i),
        .dly_done_i (dly_done_i),
        .rise_o     (rise),
        .gate_o     (sweep_gate_o),
        .sweep_rst_o(sweep_rst_o)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!sweep_gate_o && sweep_rst_o && !alt_sync_o));
    p_idle_holds_ramp_r6: assert property (@(posedge clk) disable iff (rst)
        alt_sync_o |-> sweep_rst_o);
endmodule

// File: tb/sweep_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module sweep_gate_ctrl_tb_top;
    localparam int HW = 4;
    localparam int AC = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b1;
    logic ramp = 1'b0;
    logic [1:0] mode = 2'b00;
    logic dly_en = 1'b0;
    logic dly_done = 1'b0;
    logic [HW-1:0] hold = '0;
    logic gate, srst, alt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sweep_gate_ctrl #(.HOLD_W(HW), .AUTO_CYC(AC)) dut_i (
        .clk(clk), .rst(rst), .trig_i(trig), .ramp_done_i(ramp),
        .mode_i(mode), .dly_en_i(dly_en), .dly_done_i(dly_done),
        .hold_len_i(hold), .sweep_gate_o(gate), .sweep_rst_o(srst),
        .alt_sync_o(alt)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start_hold(input int n, input logic tlev);
        hold = HW'(n);
        tick();
        ramp = 1'b1;
        trig = tlev;
        tick();
        chk("R2 alt pulse", alt, 1'b1);
        chk("R2 gate drop", gate, 1'b0);
        chk("R6 ramp reset", srst, 1'b1);
    endtask

    task automatic fire_trigger(input string tag);
        trig = 1'b0;
        tick();
        trig = 1'b1;
        tick();
        chk(tag, gate, 1'b1);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 gate", gate, 1'b0);
        chk("R1 ramp reset", srst, 1'b1);
        chk("R1 alt", alt, 1'b0);
        tick();
        chk("R1 no gate on held trigger", gate, 1'b0);

        fire_trigger("R4 first gate");
        chk("R6 gate open, ramp free", srst, 1'b0);

        for (int n = 0; n < (1 << HW); n++) begin
            // exact release probe
            start_hold(n, 1'b0);
            for (int i = 0; i <= n; i++) begin
                tick();
                if (i == 0) chk("R2 alt one cycle", alt, 1'b0);
            end
            chk("R3 gate closed through holdoff", gate, 1'b0);
            trig = 1'b1;
            ramp = 1'b0;
            tick();
            chk("R4 gate on first free rise", gate, 1'b1);
            // early probe: rise one edge before release
            start_hold(n, 1'b0);
            for (int i = 0; i < n; i++) tick();
            trig = 1'b1;
            tick();
            chk("R3 rise in holdoff ignored", gate, 1'b0);
            ramp = 1'b0;
            repeat (3) tick();
            chk("R5 high trigger at release", gate, 1'b0);
            fire_trigger("R5 fall then rise");
        end

        // holdoff extended by ramp flag
        start_hold(2, 1'b0);
        ramp = 1'b0;
        repeat (6) tick();
        trig = 1'b1;
        tick();
        chk("R3 waits for ramp flag", gate, 1'b0);
        trig = 1'b0;
        tick();
        ramp = 1'b1;
        tick();
        trig = 1'b1;
        ramp = 1'b0;
        tick();
        chk("R3 release after ramp flag", gate, 1'b1);

        // delay
        start_hold(1, 1'b0);
        repeat (2) tick();
        ramp = 1'b0;
        dly_en = 1'b1;
        trig = 1'b1;
        tick();
        chk("R7 gate open", gate, 1'b1);
        chk("R7 ramp held for delay", srst, 1'b1);
        repeat (3) tick();
        chk("R7 still waiting", srst, 1'b1);
        dly_done = 1'b1;
        tick();
        chk("R7 delay done frees ramp", srst, 1'b0);
        dly_done = 1'b0;
        tick();
        chk("R7 freed state kept", srst, 1'b0);
        dly_en = 1'b0;

        // auto timeout
        mode = 2'b01;
        hold = HW'(2);
        tick();
        fire_trigger("R8 triggered gate in auto");
        begin
            int k;
            k = 0;
            ramp = 1'b1;
            tick();
            k++;
            chk("R8 holdoff starts", alt, 1'b1);
            while (k < 4) begin
                tick();
                k++;
            end
            ramp = 1'b0;
            while (k < AC) begin
                tick();
                k++;
            end
            chk("R8 no force before timeout", gate, 1'b0);
            tick();
            chk("R8 forced gate at timeout", gate, 1'b1);
        end
        foreach (hold[j]) begin
            int n;
            n = 1 << j;
            if (n > 8) n = 0;
            start_hold(n, 1'b1);
            for (int i = 0; i <= n; i++) tick();
            chk("R8 closed until release", gate, 1'b0);
            ramp = 1'b0;
            tick();
            chk("R8 free-run after release", gate, 1'b1);
        end

        // rise restarts timeout
        start_hold(2, 1'b0);
        repeat (3) tick();
        trig = 1'b1;
        ramp = 1'b0;
        tick();
        chk("R11 trigger gate", gate, 1'b1);
        ramp = 1'b1;
        tick();
        repeat (3) tick();
        ramp = 1'b0;
        repeat (10) tick();
        chk("R11 no force after recent rise", gate, 1'b0);

        // normal mode never free-runs
        mode = 2'b00;
        repeat (3 * AC) tick();
        chk("R9 normal mode no free run", gate, 1'b0);
        mode = 2'b11;
        repeat (10) tick();
        chk("R9 code 11 acts as normal", gate, 1'b0);
        mode = 2'b00;
        fire_trigger("R9 trigger still works");

        // X-Y
        mode = 2'b10;
        tick();
        chk("R10 gate forced low", gate, 1'b0);
        ramp = 1'b1;
        for (int i = 0; i < 6; i++) begin
            trig = ~trig;
            tick();
            chk("R10 no holdoff pulse", alt, 1'b0);
            chk("R10 triggers ignored", gate, 1'b0);
        end
        ramp = 1'b0;
        mode = 2'b00;
        tick();
        fire_trigger("R10 arming after leaving");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule